// File: doc/BRIEF.md
# Audio Serial Control and Interrupt Register File

This block is the software-facing register file of an audio serial transmit/receive peripheral. A simple 32-bit, word-only register bus reaches a small window of registers. Two of them are the transmit and receive configuration words. Four hold interrupt state: raw flags, enable mask, a write-one-to-clear port and a masked status view. The last is a read-only version word.

Each configuration register has a sync bit. Software sets it to ask for the settings to be taken up. Here the bit is never stored, so a poll that reads it back sees the sync as finished at once. The start bit of the transmit configuration drives a transmit-run level to the datapath. The datapath returns a one-cycle completion strobe, which sets the transmit-done raw flag. The raw flags, gated by the enable mask, drive one level-sensitive interrupt line.

Top module: `aud_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except the version word, `tx_run_o` is low and `irq_o` is low.
- R2: A write to TXCFG (byte offset 0x00) or RXCFG (offset 0x04) stores the written word with bit 1 (the sync bit) forced to zero. Every other bit reads back as written.
- R3: `tx_run_o` equals bit 0 (start) of the most recent TXCFG write, from the cycle after that write.
- R4: Interrupt bits are: bit 0 receive done, bit 1 transmit done, bit 2 receive hung, bit 3 transmit hung. `irq_o` is high exactly when (RAW AND EN) is nonzero, from the cycle after the write that changed RAW or EN (EN at offset 0x0C, 4 bits, upper bits read zero).
- R5: Reading STAT (offset 0x14) returns RAW AND EN. Writes to STAT and to VERSION (offset 0x18, reads the `VERSION` parameter) change nothing.
- R6: A write to CLR (offset 0x10) clears only the RAW bits set in bits 3:0 of the written value. CLR reads zero.
- R7: A write to RAW (offset 0x08) replaces the RAW bits with bits 3:0 of the written value. Bits 31:4 read zero.
- R8: A one-cycle high on `tx_done_i` sets RAW bit 1 in the next cycle.
- R9: When `tx_done_i` is high in the same cycle as a CLR or RAW write, RAW bit 1 ends up set.
- R10: An access is ignored on write, and reads zero, if `bus_size` is not 2 (word; 0 is byte, 1 is half), if `bus_addr[1:0]` is nonzero, or if the address lies at or beyond 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tx_done_i | input | 1 | Transmit completion strobe |
| tx_run_o | output | 1 | Transmit-run level |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps all 256 pairings of RAW and EN, checking STAT and `irq_o`, so a design that gated the interrupt with the wrong mask or left it unrecomputed after a write would show a mismatch. It also sweeps all 256 pairings of RAW and a clear value with garbage in the upper bits. A clear that was not masked to 4 bits, or that replaced bits instead of clearing them, would leave the wrong flags. The strobe is made to collide with a clear and with a raw write, where a design that let software win would lose the completion. Byte, half-word, misaligned and out-of-window writes are aimed at RAW, and writes at STAT and VERSION. A decoder that accepted any of these would change state that the bench reads back.

// File: rtl/aud_regs_pkg.sv
// Shared constants for the audio serial register file.
// Assumes byte addressing and a power-of-two window of 32-bit words.
package aud_regs_pkg;
    localparam int DATA_W    = 32;
    localparam int IRQ_N     = 4;
    localparam int WIN_WORDS = 8;
    localparam int IDX_W     = $clog2(WIN_WORDS);

    localparam logic [1:0] SIZE_WORD = 2'd2;

    // Word indices inside the window (byte offset = index * 4).
    localparam logic [IDX_W-1:0] IDX_TXCFG = 3'd0;
    localparam logic [IDX_W-1:0] IDX_RXCFG = 3'd1;
    localparam logic [IDX_W-1:0] IDX_RAW   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_EN    = 3'd3;
    localparam logic [IDX_W-1:0] IDX_CLR   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_STAT  = 3'd5;
    localparam logic [IDX_W-1:0] IDX_VER   = 3'd6;

    // Configuration bit positions.
    localparam int RUN_BIT  = 0;
    localparam int SYNC_BIT = 1;

    // Raw interrupt bit driven by the transmit datapath.
    localparam int TXDONE_BIT = 1;

    typedef struct packed {
        logic txcfg;
        logic rxcfg;
        logic raw;
        logic en;
        logic clr;
    } wr_en_t;
endpackage

// File: rtl/aud_bus_decode.sv
// Bus decoder: qualifies an access (word size, aligned, inside the window)
// and turns it into a word index and per-register write enables.
// Assumes read accesses have no side effects.
module aud_bus_decode
    import aud_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output logic              legal,
    output logic [IDX_W-1:0]  idx,
    output wr_en_t            we
);
    localparam int WIN_BYTES = WIN_WORDS * 4;

    // Legal access: selected, whole word, aligned, inside the window.
    always_comb begin
        legal = bus_sel && (bus_size == SIZE_WORD) && (bus_addr[1:0] == 2'b00)
                && (int'(bus_addr) < WIN_BYTES);
        idx   = bus_addr[IDX_W+1:2];
    end

    // Per-register write strobes; STAT and VERSION have none.
    always_comb begin
        we       = '0;
        we.txcfg = legal && bus_wr && (idx == IDX_TXCFG);
        we.rxcfg = legal && bus_wr && (idx == IDX_RXCFG);
        we.raw   = legal && bus_wr && (idx == IDX_RAW);
        we.en    = legal && bus_wr && (idx == IDX_EN);
        we.clr   = legal && bus_wr && (idx == IDX_CLR);
    end

    assert_we_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));
    assert_no_we_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_size != SIZE_WORD || bus_addr[1:0] != 2'b00) |-> (we == '0));
endmodule

// File: rtl/aud_cfg_regs.sv
// Transmit/receive configuration words. The sync bit is never stored, so
// it reads back zero right after a write. The transmit start bit is
// exported as the run level. Assumes one-cycle write strobes.
module aud_cfg_regs #(
    parameter int DATA_W   = 32,
    parameter int SYNC_BIT = 1,
    parameter int RUN_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_we,
    input  logic              rx_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tx_cfg_q,
    output logic [DATA_W-1:0] rx_cfg_q,
    output logic              tx_run_o
);
    localparam logic [DATA_W-1:0] SYNC_MASK = DATA_W'(1) << SYNC_BIT;

    // Transmit configuration store, sync bit dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_cfg_q <= '0;
        else if (tx_we) tx_cfg_q <= wdata & ~SYNC_MASK;
    end

    // Receive configuration store, sync bit dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)     rx_cfg_q <= '0;
        else if (rx_we) rx_cfg_q <= wdata & ~SYNC_MASK;
    end

    // Run level follows the stored start bit.
    always_comb tx_run_o = tx_cfg_q[RUN_BIT];

    assert_tx_sync_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |=> (tx_cfg_q == ($past(wdata) & ~SYNC_MASK)));
    assert_rx_sync_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |=> (rx_cfg_q == ($past(wdata) & ~SYNC_MASK)));
    assert_run_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |=> (tx_run_o == $past(wdata[RUN_BIT])));
endmodule

// File: rtl/aud_irq_regs.sv
// Interrupt state: raw flags, enable mask, masked status and level output.
// Per raw bit the priority is: datapath set, then direct write, then
// write-one-to-clear. Assumes done_i is a one-cycle strobe.
module aud_irq_regs #(
    parameter int IRQ_N    = 4,
    parameter int DONE_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_we,
    input  logic             en_we,
    input  logic             clr_we,
    input  logic [IRQ_N-1:0] wdata,
    input  logic             done_i,
    output logic [IRQ_N-1:0] raw_q,
    output logic [IRQ_N-1:0] en_q,
    output logic [IRQ_N-1:0] stat,
    output logic             irq_o
);
    for (genvar b = 0; b < IRQ_N; b++) begin : g_raw
        logic set_b;
        assign set_b = (b == DONE_BIT) ? done_i : 1'b0;

        // One raw flag: hardware set beats software write and clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                   raw_q[b] <= 1'b0;
            else if (set_b)               raw_q[b] <= 1'b1;
            else if (raw_we)              raw_q[b] <= wdata[b];
            else if (clr_we && wdata[b])  raw_q[b] <= 1'b0;
        end
    end

    // Enable mask store.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wdata;
    end

    // Masked status and interrupt level.
    always_comb begin
        stat  = raw_q & en_q;
        irq_o = |stat;
    end

    assert_done_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> raw_q[DONE_BIT]);
    assert_done_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && (clr_we || raw_we)) |=> raw_q[DONE_BIT]);
    assert_clear_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !raw_we && !done_i) |=> ((raw_q & $past(wdata)) == '0));
    assert_raw_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_we && !done_i) |=> (raw_q == $past(wdata)));
    assert_enable_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (en_q == $past(wdata)));
endmodule

// File: rtl/aud_ctl_regs.sv
// Top of the audio serial control/interrupt register file. It ties the
// decoder, the configuration words and the interrupt state together and
// muxes read data. Assumes a single-cycle bus with combinational reads.
module aud_ctl_regs
    import aud_regs_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] VERSION = 32'h2025_0611
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tx_done_i,
    output logic              tx_run_o,
    output logic              irq_o
);
    logic              legal;
    logic [IDX_W-1:0]  idx;
    wr_en_t            we;
    logic [DATA_W-1:0] tx_cfg_q;
    logic [DATA_W-1:0] rx_cfg_q;
    logic [IRQ_N-1:0]  raw_q;
    logic [IRQ_N-1:0]  en_q;
    logic [IRQ_N-1:0]  stat;

    aud_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .legal    (legal),
        .idx      (idx),
        .we       (we)
    );

    aud_cfg_regs #(.DATA_W(DATA_W), .SYNC_BIT(SYNC_BIT), .RUN_BIT(RUN_BIT)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_we    (we.txcfg),
        .rx_we    (we.rxcfg),
        .wdata    (bus_wdata),
        .tx_cfg_q (tx_cfg_q),
        .rx_cfg_q (rx_cfg_q),
        .tx_run_o (tx_run_o)
    );

    aud_irq_regs #(.IRQ_N(IRQ_N), .DONE_BIT(TXDONE_BIT)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_we (we.raw),
        .en_we  (we.en),
        .clr_we (we.clr),
        .wdata  (bus_wdata[IRQ_N-1:0]),
        .done_i (tx_done_i),
        .raw_q  (raw_q),
        .en_q   (en_q),
        .stat   (stat),
        .irq_o  (irq_o)
    );

    // Read mux; illegal accesses and write-only slots read zero.
    always_comb begin
        bus_rdata = '0;
        if (legal) begin
            case (idx)
                IDX_TXCFG: bus_rdata = tx_cfg_q;
                IDX_RXCFG: bus_rdata = rx_cfg_q;
                IDX_RAW:   bus_rdata[IRQ_N-1:0] = raw_q;
                IDX_EN:    bus_rdata[IRQ_N-1:0] = en_q;
                IDX_STAT:  bus_rdata[IRQ_N-1:0] = stat;
                IDX_VER:   bus_rdata = VERSION;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_irq_tracks_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (u_irq.raw_q != '0 && (u_irq.raw_q & en_q) != '0));
    assert_illegal_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_size != SIZE_WORD) |-> (bus_rdata == '0));
endmodule

// File: tb/aud_ctl_regs_tb.sv
module aud_ctl_regs_tb_top;
    localparam logic [31:0] VER = 32'h0A5C_1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_done_i = 1'b0;
    logic        tx_run_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    aud_ctl_regs #(.ADDR_W(8), .VERSION(VER)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_done_i (tx_done_i),
        .tx_run_o  (tx_run_o),
        .irq_o     (irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write cycle: inputs set at negedge, captured at the next posedge.
    task automatic wr(logic [7:0] a, logic [31:0] d, logic [1:0] sz = 2'd2,
                      bit done = 1'b0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        tx_done_i = done;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_size = 2'd2; tx_done_i = 1'b0;
    endtask

    // Combinational read, sampled mid-cycle.
    task automatic rd(logic [7:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
        bus_sel = 1'b0; bus_size = 2'd2;
    endtask

    initial begin
        #1_000_000;
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 run", {31'b0, tx_run_o}, 32'h0);
        for (int a = 0; a < 6; a++) begin
            rd(8'(a * 4), d);
            check("R1 reg", d, 32'h0);
        end
        rd(8'h18, d);
        check("R5 version", d, VER);

        // R2 / R3 configuration words and run level
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d);
        check("R2 txcfg", d, 32'hFFFF_FFFD);
        check("R3 run on", {31'b0, tx_run_o}, 32'h1);
        wr(8'h00, 32'h0000_0002);
        rd(8'h00, d);
        check("R2 txcfg sync", d, 32'h0);
        check("R3 run off", {31'b0, tx_run_o}, 32'h0);
        wr(8'h04, 32'h1234_567B);
        rd(8'h04, d);
        check("R2 rxcfg", d, 32'h1234_5679);
        check("R3 rx no run", {31'b0, tx_run_o}, 32'h0);

        // R4 R5 R7 sweep raw x enable
        for (int r = 0; r < 16; r++) begin
            for (int e = 0; e < 16; e++) begin
                wr(8'h08, 32'hABCD_EF00 | 32'(r));
                wr(8'h0C, 32'h5555_5550 | 32'(e));
                check("R4 irq", {31'b0, irq_o}, {31'b0, ((r & e) != 0)});
                rd(8'h14, d);
                check("R5 stat", d, 32'(r & e));
            end
            rd(8'h08, d);
            check("R7 raw", d, 32'(r));
        end
        rd(8'h10, d);
        check("R6 clr reads zero", d, 32'h0);

        // R5 writes to status and version ignored
        wr(8'h08, 32'h5);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h08, d);
        check("R5 stat write", d, 32'h5);
        wr(8'h18, 32'h0);
        rd(8'h18, d);
        check("R5 version write", d, VER);

        // R6 clear sweep with upper garbage
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
                wr(8'h08, 32'(r));
                wr(8'h10, 32'hFFFF_FFF0 | 32'(c));
                rd(8'h08, d);
                check("R6 clear", d, 32'(r & ~c & 15));
            end
        end

        // R8 done strobe sets bit 1; enabled it raises irq
        wr(8'h0C, 32'h2);
        wr(8'h08, 32'h0);
        @(negedge clk); tx_done_i = 1'b1;
        @(negedge clk); tx_done_i = 1'b0;
        rd(8'h08, d);
        check("R8 done", d, 32'h2);
        check("R8 irq", {31'b0, irq_o}, 32'h1);

        // R9 done against clear and raw write in the same cycle
        wr(8'h08, 32'hF);
        wr(8'h10, 32'hF, 2'd2, 1'b1);
        rd(8'h08, d);
        check("R9 done vs clear", d, 32'h2);
        wr(8'h08, 32'h0, 2'd2, 1'b1);
        rd(8'h08, d);
        check("R9 done vs raw write", d, 32'h2);

        // R10 illegal accesses
        wr(8'h08, 32'h9);
        wr(8'h08, 32'h6, 2'd0);
        wr(8'h08, 32'h6, 2'd1);
        wr(8'h09, 32'h6);
        wr(8'h28, 32'h6);
        wr(8'h88, 32'h6);
        wr(8'h10, 32'hF, 2'd1);
        rd(8'h08, d);
        check("R10 ignored writes", d, 32'h9);
        rd(8'h08, d, 2'd0);
        check("R10 byte read", d, 32'h0);
        rd(8'h09, d);
        check("R10 misaligned read", d, 32'h0);
        rd(8'h38, d);
        check("R10 outside read", d, 32'h0);
        wr(8'h00, 32'h1, 2'd1);
        check("R10 run unchanged", {31'b0, tx_run_o}, 32'h0);

        // R1 reset again clears state
        wr(8'h00, 32'h1);
        wr(8'h0C, 32'hF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 rerun", {31'b0, tx_run_o}, 32'h0);
        check("R1 reirq", {31'b0, irq_o}, 32'h0);
        rd(8'h0C, d);
        check("R1 en", d, 32'h0);

        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule